// File: doc/BRIEF.md
# Boundary Test Pattern Engine

This block is the test-mode data engine for the boundary cells of one group of I/O pins. An external test-port state machine supplies the test clock and the capture, shift and update strobes, plus a select that directs those strobes either to the instruction register or to the data path. The instruction register is 8 bits wide and is loaded serially. It is checked for even parity when it is updated, and the check selects one of several modes.

In sample mode the engine observes the input pins and preloads the drive latch, while the pins keep their functional values. The test modes take over the output pins. They are parallel signature analysis of the input pins through a mask, pseudo-random generation, toggling, binary counting, and counting combined with signature analysis. Every pattern mode advances once per data update strobe. Each pin has two cells: a capture cell in the boundary shift register and a separate forcing cell that drives the pin. Forced pin values and the serial output change on the falling edge of the test clock.

Top module: `bte_engine`

## Requirements
- R1: The instruction register shifts TDI in at bit 7 and shifts bit 0 out first. Capture loads 0x01. Update decodes the 8-bit code, with bit 7 as the even-parity bit over all 8 bits: 0x81 sample, 0x03 signature, 0x05 pseudo-random, 0x06 toggle, 0x87 count, 0x09 signature+count, 0x0A mask load, 0xFF bypass.
- R2: A code with odd parity, or an even-parity code not in the R1 list, selects bypass. Bypass uses a 1-bit register that captures 0 and shifts TDI. The pins then carry `func_out`.
- R3: Outside bypass, the W-bit boundary register captures `pin_in`. In the signature and signature+count modes it captures the signature instead. It shifts TDI into bit W-1 and sends bit 0 to TDO.
- R4: In sample mode the pins carry `func_out`, and a data update copies the boundary register into the drive latch, which later test modes present.
- R5: Loading any instruction clears the signature. In the signature modes, each data update computes t = sig XOR (pin_in AND mask) and then sig = {t[W-2:0], t[W-1] XOR t[10]} (polynomial x^18+x^11+1).
- R6: The mask register resets to all ones. Only a data update under mask load changes it, copying the boundary register. A 1 bit includes that input.
- R7: Pseudo-random: the first data update after the instruction load seeds the pattern from the boundary register, and an all-zero seed becomes 1. Each later update advances the pattern one step of the R5 shift without input.
- R8: Toggle: the first data update loads the boundary register and each later update inverts every forced bit. Capture still samples `pin_in`.
- R9: Count and signature+count: the first data update loads the boundary register and each later update adds 1 modulo 2^W.
- R10: In signature+count, a single data update both folds the inputs into the signature and steps the count.
- R11: In the test modes `pin_out` carries the forced value, and in all other modes it carries `func_out`. Changes to `pin_out` and TDO appear at the falling test-clock edge after the rising edge that caused them.
- R12: A low `trst_n` at once selects bypass, returns the pins to `func_out`, clears the signature and pattern, and sets the mask to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_sel | input | 1 | 1 directs the strobes to the instruction register, 0 to the data path |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial test data in |
| pin_in | input | W | Values present at the input pins |
| func_out | input | W | Functional values for the output pins |
| pin_out | output | W | Values driven onto the output pins |
| tdo | output | 1 | Serial test data out, changes on the falling edge |

## Verification
In signature+count mode a single update strobe both folds the masked inputs into the signature and steps the output count. The seeding update also folds the inputs. The bench loads that instruction, seeds the count through a scan and then applies a further update with new pin values. It judges the pins against the expected count and reads the signature back through a capture scan, comparing it with two independently computed folds. A second overlap is a pattern step and its appearance on the pins. The bench checks it by sampling `pin_out` just after the rising edge, where the old value must remain, and again after the falling edge.

// File: rtl/bte_pkg.sv
`timescale 1ns/1ps
package bte_pkg;
  localparam int IR_W = 8;

  typedef enum logic [2:0] {
    M_BYPASS, M_SAMPLE, M_PSA, M_PRPG, M_TOGGLE, M_COUNT, M_PSACNT, M_MASKLD
  } bte_mode_e;

  // low seven bits of each code; bit 7 carries even parity
  localparam logic [IR_W-2:0] OP_SAMPLE = 7'h01;
  localparam logic [IR_W-2:0] OP_PSA    = 7'h03;
  localparam logic [IR_W-2:0] OP_PRPG   = 7'h05;
  localparam logic [IR_W-2:0] OP_TOGGLE = 7'h06;
  localparam logic [IR_W-2:0] OP_COUNT  = 7'h07;
  localparam logic [IR_W-2:0] OP_PSACNT = 7'h09;
  localparam logic [IR_W-2:0] OP_MASKLD = 7'h0A;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;
  localparam logic [IR_W-1:0] IR_RESET   = 8'hFF;

  function automatic logic ir_parity_ok(input logic [IR_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic bte_mode_e ir_decode(input logic [IR_W-1:0] v);
    bte_mode_e m;
    m = M_BYPASS;
    if (ir_parity_ok(v)) begin
      case (v[IR_W-2:0])
        OP_SAMPLE: m = M_SAMPLE;
        OP_PSA:    m = M_PSA;
        OP_PRPG:   m = M_PRPG;
        OP_TOGGLE: m = M_TOGGLE;
        OP_COUNT:  m = M_COUNT;
        OP_PSACNT: m = M_PSACNT;
        OP_MASKLD: m = M_MASKLD;
        default:   m = M_BYPASS;
      endcase
    end
    return m;
  endfunction

  function automatic logic is_test_mode(input bte_mode_e m);
    return (m == M_PSA) || (m == M_PRPG) || (m == M_TOGGLE) ||
           (m == M_COUNT) || (m == M_PSACNT);
  endfunction

  function automatic logic is_sig_mode(input bte_mode_e m);
    return (m == M_PSA) || (m == M_PSACNT);
  endfunction

  function automatic logic is_pattern_mode(input bte_mode_e m);
    return (m == M_PRPG) || (m == M_TOGGLE) || (m == M_COUNT) || (m == M_PSACNT);
  endfunction
endpackage

// File: rtl/bte_ireg.sv
`timescale 1ns/1ps
module bte_ireg
  import bte_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  logic      ir_cap,
  input  logic      ir_shift,
  input  logic      ir_upd,
  input  logic      tdi,
  output logic      ir_tdo,
  output bte_mode_e mode
);
  logic [IR_W-1:0] ir_sr;
  logic            parity_err;

  assign parity_err = ~ir_parity_ok(ir_sr);
  assign ir_tdo     = ir_sr[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_RESET;
      mode  <= M_BYPASS;
    end else begin
      if (ir_cap)        ir_sr <= IR_CAPTURE;
      else if (ir_shift) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (ir_upd)        mode  <= ir_decode(ir_sr);
    end
  end

  AST_PARITY_SAFE: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_upd && parity_err) |=> (mode == M_BYPASS)); // R2
  AST_MODE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !ir_upd |=> $stable(mode)); // R1
endmodule

// File: rtl/bte_dreg.sv
`timescale 1ns/1ps
module bte_dreg
  import bte_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         dr_cap,
  input  logic         dr_shift,
  input  logic         dr_upd,
  input  logic         tdi,
  input  bte_mode_e    mode,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] sig,
  output logic         dr_tdo,
  output logic [W-1:0] bsr,
  output logic [W-1:0] mask
);
  logic byp;
  logic in_bypass;
  logic mask_load;

  assign in_bypass = (mode == M_BYPASS);
  assign mask_load = dr_upd && (mode == M_MASKLD);
  assign dr_tdo    = in_bypass ? byp : bsr[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp <= 1'b0;
      bsr <= '0;
    end else if (in_bypass) begin
      if (dr_cap)        byp <= 1'b0;
      else if (dr_shift) byp <= tdi;
    end else begin
      if (dr_cap)        bsr <= is_sig_mode(mode) ? sig : pin_in;
      else if (dr_shift) bsr <= {tdi, bsr[W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        mask <= '1;
    else if (mask_load) mask <= bsr;
  end

  AST_MASK_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !mask_load |=> $stable(mask)); // R6
  AST_BSR_IDLE_IN_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
    in_bypass |=> $stable(bsr)); // R2
endmodule

// File: rtl/bte_pattern.sv
`timescale 1ns/1ps
module bte_pattern
  import bte_pkg::*;
#(
  parameter int W   = 18,
  parameter int TAP = 11
) (
  input  logic         tck,
  input  logic         trst_n,
  input  bte_mode_e    mode,
  input  logic         ir_upd,
  input  logic         dr_upd,
  input  logic [W-1:0] bsr,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] mask,
  output logic [W-1:0] pat,
  output logic [W-1:0] sig
);
  function automatic logic [W-1:0] lfsr_adv(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP-1]};
  endfunction

  function automatic logic [W-1:0] misr_adv(input logic [W-1:0] s, input logic [W-1:0] d);
    return lfsr_adv(s ^ d);
  endfunction

  function automatic logic [W-1:0] nonzero(input logic [W-1:0] s);
    return (s == '0) ? {{(W-1){1'b0}}, 1'b1} : s;
  endfunction

  logic         seed_pend;
  logic         sig_fold;
  logic         pat_step;
  logic         pat_seed;
  logic [W-1:0] pat_next;

  assign sig_fold = dr_upd && is_sig_mode(mode);
  assign pat_step = dr_upd && is_pattern_mode(mode);
  assign pat_seed = pat_step && seed_pend;

  always_comb begin
    case (mode)
      M_PRPG:   pat_next = seed_pend ? nonzero(bsr) : lfsr_adv(pat);
      M_TOGGLE: pat_next = seed_pend ? bsr : ~pat;
      default:  pat_next = seed_pend ? bsr : pat + 1'b1;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pat       <= '0;
      sig       <= '0;
      seed_pend <= 1'b1;
    end else if (ir_upd) begin
      sig       <= '0;
      seed_pend <= 1'b1;
    end else if (dr_upd) begin
      if (sig_fold) sig <= misr_adv(sig, pin_in & mask);
      if (mode == M_SAMPLE) begin
        pat <= bsr;
      end else if (pat_step) begin
        pat       <= pat_next;
        seed_pend <= 1'b0;
      end
    end
  end

  AST_PRPG_NONZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_upd && mode == M_PRPG) |=> (pat != '0)); // R7
  AST_TOGGLE_INV: assert property (@(posedge tck) disable iff (!trst_n)
    (pat_step && !pat_seed && mode == M_TOGGLE) |=> (pat == ~$past(pat))); // R8
  AST_COUNT_INC: assert property (@(posedge tck) disable iff (!trst_n)
    (pat_step && !pat_seed && (mode == M_COUNT || mode == M_PSACNT))
    |=> (pat == W'($past(pat) + 1'b1))); // R9
  AST_SIG_CLEAR: assert property (@(posedge tck) disable iff (!trst_n)
    ir_upd |=> (sig == '0)); // R5
  AST_SIG_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !(ir_upd || sig_fold) |=> $stable(sig)); // R5
endmodule

// File: rtl/bte_outstage.sv
`timescale 1ns/1ps
module bte_outstage
  import bte_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         tck,
  input  logic         trst_n,
  input  bte_mode_e    mode,
  input  logic [W-1:0] pat,
  input  logic         tdo_next,
  input  logic [W-1:0] func_out,
  output logic [W-1:0] pin_out,
  output logic         tdo
);
  logic [W-1:0] drv_q;
  logic         force_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      drv_q   <= '0;
      force_q <= 1'b0;
      tdo     <= 1'b0;
    end else begin
      drv_q   <= pat;
      force_q <= is_test_mode(mode);
      tdo     <= tdo_next;
    end
  end

  assign pin_out = force_q ? drv_q : func_out;
endmodule

// File: rtl/bte_engine.sv
`timescale 1ns/1ps
module bte_engine
  import bte_pkg::*;
#(
  parameter int W   = 18,
  parameter int TAP = 11
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         ir_sel,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         tdi,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] func_out,
  output logic [W-1:0] pin_out,
  output logic         tdo
);
  bte_mode_e    mode;
  logic         ir_cap, ir_shift, ir_upd;
  logic         dr_cap, dr_shift, dr_upd;
  logic         ir_tdo, dr_tdo;
  logic [W-1:0] bsr, mask, pat, sig;

  assign ir_cap   = ir_sel & capture_en;
  assign ir_shift = ir_sel & shift_en;
  assign ir_upd   = ir_sel & update_en;
  assign dr_cap   = ~ir_sel & capture_en;
  assign dr_shift = ~ir_sel & shift_en;
  assign dr_upd   = ~ir_sel & update_en;

  bte_ireg u_ireg (
    .tck(tck), .trst_n(trst_n), .ir_cap(ir_cap), .ir_shift(ir_shift),
    .ir_upd(ir_upd), .tdi(tdi), .ir_tdo(ir_tdo), .mode(mode)
  );

  bte_dreg #(.W(W)) u_dreg (
    .tck(tck), .trst_n(trst_n), .dr_cap(dr_cap), .dr_shift(dr_shift),
    .dr_upd(dr_upd), .tdi(tdi), .mode(mode), .pin_in(pin_in), .sig(sig),
    .dr_tdo(dr_tdo), .bsr(bsr), .mask(mask)
  );

  bte_pattern #(.W(W), .TAP(TAP)) u_pattern (
    .tck(tck), .trst_n(trst_n), .mode(mode), .ir_upd(ir_upd), .dr_upd(dr_upd),
    .bsr(bsr), .pin_in(pin_in), .mask(mask), .pat(pat), .sig(sig)
  );

  bte_outstage #(.W(W)) u_out (
    .tck(tck), .trst_n(trst_n), .mode(mode), .pat(pat),
    .tdo_next(ir_sel ? ir_tdo : dr_tdo), .func_out(func_out),
    .pin_out(pin_out), .tdo(tdo)
  );
endmodule

// File: tb/bte_engine_tb_top.sv
`timescale 1ns/1ps
module bte_engine_tb_top;
  localparam int W = 18;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic ir_sel = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic [W-1:0] pin_in = '0, func_out = '0;
  logic [W-1:0] pin_out;
  logic tdo;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic s_tdo;
  logic [W-1:0] s_pin;

  always #5 tck = ~tck;

  bte_engine dut_i (
    .tck(tck), .trst_n(trst_n), .ir_sel(ir_sel), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .pin_in(pin_in),
    .func_out(func_out), .pin_out(pin_out), .tdo(tdo)
  );

  // shift register model: bit 0 receives the XOR of bit 17 and bit 10
  function automatic logic [W-1:0] m_step(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s << 1;
    r[0] = s[W-1] ^ s[10];
    return r;
  endfunction

  function automatic logic [W-1:0] m_fold(input logic [W-1:0] s, input logic [W-1:0] d,
                                          input logic [W-1:0] m);
    return m_step(s ^ (d & m));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic is_ir, input logic cap, input logic sh,
                     input logic up, input logic td);
    @(negedge tck); #1;
    s_tdo = tdo; s_pin = pin_out;
    ir_sel = is_ir; capture_en = cap; shift_en = sh; update_en = up; tdi = td;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

  task automatic scan_ir(input logic [7:0] v, output logic [7:0] got);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 1, 0, v[i]);
      got[i] = s_tdo;
    end
    cyc(1, 0, 0, 1, 0);
    idle();
  endtask

  task automatic scan_dr(input logic [W-1:0] v, input bit upd, output logic [W-1:0] got);
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < W; i++) begin
      cyc(0, 0, 1, 0, v[i]);
      got[i] = s_tdo;
    end
    if (upd) cyc(0, 0, 0, 1, 0);
    idle();
  endtask

  task automatic step(); cyc(0, 0, 0, 1, 0); idle(); endtask

  logic [7:0] ig;
  logic [W-1:0] dg;
  logic [W-1:0] mask_v = 18'h0F0F3;
  logic [W-1:0] preload_v = 18'h2A5C3;

  task automatic t_reset();
    func_out = 18'h15A5A;
    idle();
    chk(s_pin == func_out, "R12 reset pins functional", s_pin, func_out);
  endtask

  task automatic t_ir_sample();
    scan_ir(8'h81, ig);
    chk(ig == 8'h01, "R1 IR capture value", W'(ig), W'(8'h01));
    pin_in = 18'h3C0F1;
    scan_dr(preload_v, 1, dg);
    chk(dg == 18'h3C0F1, "R3 sample captures pin_in", dg, 18'h3C0F1);
    chk(s_pin == func_out, "R4 sample keeps pins functional", s_pin, func_out);
    scan_ir(8'h03, ig);
    chk(s_pin == preload_v, "R4 R11 preload forced in signature mode", s_pin, preload_v);
    scan_dr('0, 0, dg);
    chk(dg == '0, "R5 signature cleared on load", dg, '0);
  endtask

  task automatic t_parity();
    logic [W-1:0] v;
    v = 18'h2D3B1;
    scan_ir(8'h83, ig);
    chk(s_pin == func_out, "R2 odd parity leaves pins functional", s_pin, func_out);
    scan_dr(v, 1, dg);
    chk(dg == {v[W-2:0], 1'b0}, "R2 odd parity gives one-bit bypass", dg, {v[W-2:0], 1'b0});
    scan_ir(8'h00, ig);
    scan_dr(v, 1, dg);
    chk(dg == {v[W-2:0], 1'b0}, "R2 unlisted code gives bypass", dg, {v[W-2:0], 1'b0});
  endtask

  task automatic t_mask_psa();
    logic [W-1:0] e, d1, d2;
    scan_ir(8'h0A, ig);
    scan_dr(mask_v, 1, dg);
    scan_ir(8'h81, ig);
    scan_dr(~mask_v, 1, dg);
    scan_ir(8'h03, ig);
    chk(s_pin == ~mask_v, "R11 signature mode forces latch", s_pin, ~mask_v);
    d1 = 18'h3FFFF; d2 = 18'h12345;
    pin_in = d1; step();
    pin_in = d2; step();
    e = m_fold(m_fold('0, d1, mask_v), d2, mask_v);
    scan_dr('0, 0, dg);
    chk(dg == e, "R5 R6 masked signature", dg, e);
  endtask

  task automatic t_prpg();
    logic [W-1:0] e;
    scan_ir(8'h05, ig);
    scan_dr('0, 1, dg);
    e = 18'h00001;
    chk(s_pin == e, "R7 zero seed replaced by one", s_pin, e);
    for (int k = 0; k < 3; k++) begin
      step();
      e = m_step(e);
      chk(s_pin == e, "R7 pseudo-random step", s_pin, e);
    end
    scan_ir(8'h05, ig);
    scan_dr(18'h2B1C7, 1, dg);
    chk(s_pin == 18'h2B1C7, "R7 reseed on new load", s_pin, 18'h2B1C7);
    cyc(0, 0, 0, 1, 0);
    @(posedge tck); #1;
    chk(pin_out == 18'h2B1C7, "R11 pins hold through rising edge", pin_out, 18'h2B1C7);
    idle();
    e = m_step(18'h2B1C7);
    chk(s_pin == e, "R11 pins change at falling edge", s_pin, e);
  endtask

  task automatic t_toggle();
    logic [W-1:0] t;
    t = 18'h0C3A5;
    scan_ir(8'h06, ig);
    pin_in = 18'h1E1E1;
    scan_dr(t, 1, dg);
    chk(dg == 18'h1E1E1, "R8 toggle capture samples inputs", dg, 18'h1E1E1);
    chk(s_pin == t, "R8 toggle seed", s_pin, t);
    step();
    chk(s_pin == ~t, "R8 toggle inverts", s_pin, ~t);
    step();
    chk(s_pin == t, "R8 toggle inverts back", s_pin, t);
  endtask

  task automatic t_count();
    scan_ir(8'h87, ig);
    scan_dr(18'h3FFFE, 1, dg);
    chk(s_pin == 18'h3FFFE, "R9 count seed", s_pin, 18'h3FFFE);
    step();
    chk(s_pin == 18'h3FFFF, "R9 count increment", s_pin, 18'h3FFFF);
    step();
    chk(s_pin == '0, "R9 count wraps", s_pin, '0);
  endtask

  task automatic t_psacnt();
    logic [W-1:0] e, p0, d1;
    p0 = 18'h2F00D; d1 = 18'h0BEEF;
    scan_ir(8'h09, ig);
    pin_in = p0;
    scan_dr(18'h00100, 1, dg);
    chk(s_pin == 18'h00100, "R10 combined seed", s_pin, 18'h00100);
    pin_in = d1;
    step();
    chk(s_pin == 18'h00101, "R10 combined count step", s_pin, 18'h00101);
    e = m_fold(m_fold('0, p0, mask_v), d1, mask_v);
    scan_dr('0, 0, dg);
    chk(dg == e, "R10 combined signature", dg, e);
  endtask

  task automatic t_reset_mid();
    logic [W-1:0] v;
    scan_ir(8'h87, ig);
    scan_dr(18'h00055, 1, dg);
    @(negedge tck); #3;
    trst_n = 1'b0; #1;
    chk(pin_out == func_out, "R12 async reset frees pins", pin_out, func_out);
    @(negedge tck); #1; trst_n = 1'b1;
    v = 18'h1A2B3;
    scan_dr(v, 1, dg);
    chk(dg == {v[W-2:0], 1'b0}, "R12 reset selects bypass", dg, {v[W-2:0], 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    t_reset();
    t_ir_sample();
    t_parity();
    t_mask_psa();
    t_prpg();
    t_toggle();
    t_count();
    t_psacnt();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL R12 watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule